// File: doc/BRIEF.md
# Eight-Channel Programmable-Resolution PWM Bank

This block drives eight pulse-width-modulated outputs meant to be low-pass filtered into analog control voltages. All eight channels share a single counter that moves forward once every `PRESCALE` core clocks. Each channel compares that counter against its own 8-bit duty value. A resolution setting of N bits, from 1 to 8, shortens the counter cycle to 2^N steps. Lower resolution therefore gives a faster repetition rate. With the default prescale of two, a 12 MHz core clock and full 8-bit resolution, one frame lasts 512 clocks, which is about 23.4 kHz.

Each output is a pull-down enable for an open-drain pad. A one means the pin is pulled low. A zero means the pin is released. No path in the block ever drives a pin high. Software writes through a simple write port. A duty or resolution value written to the port waits in a pending register. It is copied to the working register only when the counter wraps, so a frame in progress never changes its shape.

Top module: `pwm_bank_top`

## Requirements
- R1: While reset is held and right after its release, every pull-enable is 0, every duty is 0 and the resolution is 8 bits.
- R2: The shared counter advances once per `PRESCALE` (default 2) core clocks, so at 8-bit resolution a frame lasts 512 clocks.
- R3: Channel i asserts its pull-enable while the counter is below the compared duty field, giving `PRESCALE` × duty clocks of pull-down per frame.
- R4: A write to address 8 sets the resolution to N = wrData[2:0] + 1 bits, and one frame then lasts `PRESCALE` × 2^N clocks.
- R5: A duty of 0 keeps the pull-enable at 0 for whole frames.
- R6: A duty whose compared bits are all ones keeps the pull-enable at 1 for every count of a frame except the last one.
- R7: At N-bit resolution only the upper N bits of the duty, wrData[7:8-N], are compared with the counter.
- R8: Duty writes (addresses 0 to 7 select the channel) and resolution writes take effect only at the next counter wrap. The frame in progress keeps its old values.
- R9: All channels begin their frames on the same clock edge.
- R10: Writes to addresses 9 to 15 change neither an output nor the resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| wrAddr | input | 4 | Register address: 0-7 duty of a channel, 8 resolution |
| wrData | input | 8 | Write data |
| pwmDrainEn | output | 8 | Per-channel pull-down enable (1 = pin pulled low, 0 = released) |

## Verification
A wrong counter or prescaler state changes the frame length. The error shows within one frame as a rising-edge spacing at an output that is not `PRESCALE` × 2^N. A working duty register that is corrupted, or loaded at the wrong time, changes the pull-down width. Loading outside a wrap shows at the ports within a few clocks of the write, as an edge in the middle of a frame. A reference model in the bench is compared with all eight outputs on every clock. This comparison catches any divergence on the cycle it first appears.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic tick;   // counter advances on this edge
    logic wrap;   // counter returns to zero; pending values become working
  } pwm_strobe_t;
endpackage

// File: rtl/pwm_bank_ctrl.sv
module pwm_bank_ctrl
  import pwm_bank_pkg::*;
#(
  parameter int DUTY_W   = 8,
  parameter int PRESCALE = 2,
  parameter int NUM_CH   = 8,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DUTY_W-1:0] wrData,
  output pwm_strobe_t       strb,
  output logic [DUTY_W-1:0] count,
  output logic [$clog2(DUTY_W+1)-1:0] activeRes
);
  localparam int RES_W  = $clog2(DUTY_W + 1);
  localparam int CODE_W = $clog2(DUTY_W);
  localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PRE_W-1:0]  preCnt;
  logic [RES_W-1:0]  pendingRes;
  logic [DUTY_W:0]   lastCount;
  logic              resWrite;

  assign resWrite  = wrEn && (wrAddr == ADDR_W'(NUM_CH));
  assign lastCount = ({{DUTY_W{1'b0}}, 1'b1} << activeRes) - 1'b1;
  assign strb.tick = (preCnt == PRE_W'(PRESCALE - 1));
  assign strb.wrap = strb.tick && ({1'b0, count} == lastCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt     <= '0;
      count      <= '0;
      activeRes  <= RES_W'(DUTY_W);
      pendingRes <= RES_W'(DUTY_W);
    end else begin
      if (resWrite)
        pendingRes <= RES_W'(wrData[CODE_W-1:0]) + RES_W'(1);
      if (strb.tick) begin
        preCnt <= '0;
        if (strb.wrap) begin
          count     <= '0;
          activeRes <= pendingRes;
        end else begin
          count <= count + 1'b1;
        end
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_bank_datapath.sv
module pwm_bank_datapath
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DUTY_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DUTY_W-1:0]        wrData,
  input  pwm_strobe_t              strb,
  input  logic [DUTY_W-1:0]        count,
  input  logic [$clog2(DUTY_W+1)-1:0] activeRes,
  output logic [NUM_CH-1:0]        pwmDrainEn,
  output logic [NUM_CH*DUTY_W-1:0] activeDutyFlat
);
  localparam int RES_W = $clog2(DUTY_W + 1);

  logic [RES_W-1:0] dropBits;
  assign dropBits = RES_W'(DUTY_W) - activeRes;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [DUTY_W-1:0] pendingDuty;
    logic [DUTY_W-1:0] activeDuty;
    logic [DUTY_W-1:0] cmpDuty;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendingDuty <= '0;
        activeDuty  <= '0;
      end else begin
        if (wrEn && (wrAddr == ADDR_W'(ch)))
          pendingDuty <= wrData;
        if (strb.wrap)
          activeDuty <= pendingDuty;
      end
    end

    // only the upper activeRes bits take part in the compare
    assign cmpDuty    = activeDuty >> dropBits;
    assign pwmDrainEn[ch] = (count < cmpDuty);
    assign activeDutyFlat[ch*DUTY_W +: DUTY_W] = activeDuty;
  end
endmodule

// File: rtl/pwm_bank_top.sv
module pwm_bank_top
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int DUTY_W   = 8,
  parameter int PRESCALE = 2,
  localparam int ADDR_W  = $clog2(NUM_CH + 1) + ((NUM_CH + 1 > 8) ? 0 : 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DUTY_W-1:0] wrData,
  output logic [NUM_CH-1:0] pwmDrainEn
);
  localparam int RES_W = $clog2(DUTY_W + 1);

  pwm_strobe_t             strb;
  logic [DUTY_W-1:0]       count;
  logic [RES_W-1:0]        activeRes;
  logic [NUM_CH*DUTY_W-1:0] activeDutyFlat;

  pwm_bank_ctrl #(
    .DUTY_W(DUTY_W), .PRESCALE(PRESCALE), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .count(count), .activeRes(activeRes)
  );

  pwm_bank_datapath #(
    .NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .ADDR_W(ADDR_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .count(count), .activeRes(activeRes),
    .pwmDrainEn(pwmDrainEn), .activeDutyFlat(activeDutyFlat)
  );
endmodule

// File: rtl/pwm_bank_checker.sv
module pwm_bank_checker
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DUTY_W = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input pwm_strobe_t                strb,
  input logic [DUTY_W-1:0]          count,
  input logic [$clog2(DUTY_W+1)-1:0] activeRes,
  input logic [NUM_CH*DUTY_W-1:0]   activeDutyFlat,
  input logic [NUM_CH-1:0]          pwmDrainEn
);
  // R1: pins released whenever reset is held
  p_reset_released_r1: assert property (@(posedge clk)
    !rstN |-> (pwmDrainEn == '0));

  // R2: counter holds between prescaler ticks
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tick |=> $stable(count));

  // R4: counter never leaves the range set by the working resolution
  p_count_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, count} >> activeRes) == '0);

  // R8: working duties and resolution change only at a wrap
  p_update_at_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrap |=> ($stable(activeDutyFlat) && $stable(activeRes)));

  // R9: after a wrap every channel restarts from count zero
  p_common_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrap |=> (count == '0));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R5: zero duty never pulls the pin
    p_zero_duty_r5: assert property (@(posedge clk) disable iff (!rstN)
      (activeDutyFlat[ch*DUTY_W +: DUTY_W] == '0) |-> !pwmDrainEn[ch]);
  end
endmodule

bind pwm_bank_top pwm_bank_checker #(
  .NUM_CH(NUM_CH), .DUTY_W(DUTY_W)
) chk_i (
  .clk(clk), .rstN(rstN), .strb(strb), .count(count),
  .activeRes(activeRes), .activeDutyFlat(activeDutyFlat),
  .pwmDrainEn(pwmDrainEn)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRESCALE   = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] pwmDrainEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit modelOn = 0;

  pwm_bank_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmDrainEn(pwmDrainEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model from the requirements ----------------
  int mPre, mCnt, mRes, mResPend;
  logic [7:0] mDuty [8];
  logic [7:0] mPend [8];

  function automatic bit refPull(int cnt, int res, logic [7:0] duty);
    int field;
    field = int'(duty) >> (8 - res);   // R7: upper res bits only
    return cnt < field;                 // R3
  endfunction

  function automatic logic [7:0] refVec();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = refPull(mCnt, mRes, mDuty[i]);
    return v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPre <= 0; mCnt <= 0; mRes <= 8; mResPend <= 8;
      for (int i = 0; i < 8; i++) begin mDuty[i] <= '0; mPend[i] <= '0; end
    end else begin
      if (wrEn && wrAddr < 8) mPend[wrAddr[2:0]] <= wrData;
      if (wrEn && wrAddr == 8) mResPend <= int'(wrData[2:0]) + 1;
      if (mPre == PRESCALE - 1) begin
        mPre <= 0;
        if (mCnt == (1 << mRes) - 1) begin
          mCnt <= 0; mRes <= mResPend;
          for (int i = 0; i < 8; i++) mDuty[i] <= mPend[i];
        end else mCnt <= mCnt + 1;
      end else mPre <= mPre + 1;
    end
  end

  always @(negedge clk) begin
    if (modelOn && rstN && !done) begin
      checks++;
      if (pwmDrainEn !== refVec()) begin
        errors++;
        $display("FAIL R3 model compare at %0t: actual %b expected %b", $time, pwmDrainEn, refVec());
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input int addr, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(addr); wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // waits for a rising pull-enable, then measures frame length and active clocks
  task automatic measure(input int ch, output int period, output int high);
    logic prev;
    prev = pwmDrainEn[ch];
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (pwmDrainEn[ch] && !prev) break;
      prev = pwmDrainEn[ch];
    end
    high = 1; period = 0; prev = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      period++;
      if (pwmDrainEn[ch] && !prev) break;
      high += int'(pwmDrainEn[ch]);
      prev = pwmDrainEn[ch];
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int per, hi, stuck;
    logic [7:0] prevVec;
    void'($urandom(32'h5eed_1234));

    idle(3);
    check("R1 pull-enables during reset", int'(pwmDrainEn), 0);
    @(negedge clk); rstN = 1'b1;
    modelOn = 1;
    idle(2);
    check("R1 pull-enables after reset", int'(pwmDrainEn), 0);

    // full resolution, half duty
    writeReg(0, 128);
    measure(0, per, hi);
    check("R2 frame length at 8 bits", per, PRESCALE * 256);
    check("R3 active clocks for duty 128", hi, PRESCALE * 128);

    // all-ones duty at 8 bits
    writeReg(0, 255);
    idle(600);
    measure(0, per, hi);
    check("R6 active clocks for duty 255", hi, PRESCALE * 255);
    check("R6 frame length for duty 255", per, PRESCALE * 256);

    // 4-bit resolution: code 3
    writeReg(8, 3);
    writeReg(0, 8'h8F);
    writeReg(2, 8'hF0);
    idle(600);
    measure(0, per, hi);
    check("R4 frame length at 4 bits", per, PRESCALE * 16);
    check("R7 upper nibble of 0x8F compared", hi, PRESCALE * 8);
    measure(2, per, hi);
    check("R6 all-ones nibble at 4 bits", hi, PRESCALE * 15);

    // zero duty
    writeReg(0, 0);
    idle(80);
    stuck = 0;
    for (int k = 0; k < 200; k++) begin @(negedge clk); stuck += int'(pwmDrainEn[0]); end
    check("R5 zero duty active clocks", stuck, 0);

    // back to 8 bits: mid-frame write must wait for the wrap
    writeReg(8, 7);
    writeReg(1, 200);
    idle(600);
    measure(1, per, hi);
    idle(20);
    writeReg(1, 5);
    idle(3);
    check("R8 output held after mid-frame write", int'(pwmDrainEn[1]), 1);
    measure(1, per, hi);
    check("R8 new duty applied next frame", hi, PRESCALE * 5);

    // common frame start
    for (int i = 0; i < 8; i++) writeReg(i, 1 + i * 30);
    idle(600);
    prevVec = pwmDrainEn;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (pwmDrainEn[0] && !prevVec[0]) break;
      prevVec = pwmDrainEn;
    end
    check("R9 all channels before frame start", int'(prevVec), 0);
    check("R9 all channels at frame start", int'(pwmDrainEn), 8'hFF);

    // unused addresses
    for (int i = 0; i < 8; i++) writeReg(i, 0);
    idle(600);
    for (int a = 9; a < 16; a++) writeReg(a, 8'hFF);
    stuck = 0;
    for (int k = 0; k < 1100; k++) begin @(negedge clk); stuck += int'(pwmDrainEn != 0); end
    check("R10 outputs after unused-address writes", stuck, 0);
    writeReg(0, 64);
    idle(600);
    measure(0, per, hi);
    check("R10 resolution kept after unused-address writes", per, PRESCALE * 256);
    check("R3 active clocks for duty 64", hi, PRESCALE * 64);

    // random writes, checked every clock by the model
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if ($urandom_range(39, 0) == 0) begin
        wrEn = 1'b1;
        wrAddr = 4'($urandom_range(15, 0));
        wrData = 8'($urandom_range(255, 0));
      end else wrEn = 1'b0;
    end
    @(negedge clk); wrEn = 1'b0;
    idle(4);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule